// File: doc/BRIEF.md
# Twisted-Ring Timing Strobe Generator

This block produces a repeating train of eight non-overlapping timing strobes from a four-stage twisted-ring (switch-tail) shift counter. The first stage loads the inverse of the last stage, and every other stage loads the stage ahead of it. Four flip-flops therefore walk through eight distinct codes. Each code is then turned into a one-hot strobe by an AND term that looks at only two stage outputs. Control logic elsewhere uses these strobes to sequence eight phases of an operation.

A plain twisted ring that picks up an illegal code, for example after an upset, keeps cycling through illegal codes for ever. Here the input of the third stage is built so that every one of the eight unused codes drains back into the legal cycle within a few enabled clocks. A synchronous reset clears the ring. An enable input lets the ring advance or hold.

Top module: `jc_timing_gen`

## Requirements
- R1: A synchronous reset sampled high clears `ring_q` to 0000, and `strobe` then reads 8'h01.
- R2: With `en` high and no reset, every clock moves `ring_q` through the cycle 0, 8, C, E, F, 7, 3, 1 (hex) and back to 0. Bit 3 is the first stage and bit 0 the last. The first stage takes the inverse of bit 0, and bits 2 and 0 take bits 3 and 1.
- R3: In the k-th code of that cycle (k = 0..7), only `strobe[k]` is high.
- R4: Each strobe is a two-input AND of stage levels. With first..last stages named P, Q, S, T, the strobes 0..7 are P'T', PQ', QS', ST', PT, P'Q, Q'S, S'T. The illegal code 4 reads 8'h25, code A reads 8'h4A and code 9 reads 8'h92.
- R5: With `en` low, `ring_q` and `strobe` keep their values, legal or not.
- R6: The third stage (bit 1) loads (bit 3 OR bit 1) AND bit 2. From any of the eight unused codes, at most five enabled clocks bring the ring back into the legal cycle. Code 6 steps to B, and code A steps to D.
- R7: Reset takes priority over `en`. A clock with both high yields 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the ring when high, hold when low |
| ring_q | output | 4 | Ring stage levels, bit 3 first stage, bit 0 last stage |
| strobe | output | 8 | One-hot timing strobes decoded from the ring |

## Verification
Two pairs of functions can land on the same clock edge. Reset and advance meet when `rst` and `en` are both high. This is provoked with the ring parked mid-cycle, and it is judged by the ring reading 0000 rather than the successor code. Hold and repair meet when an illegal code sits in the ring while `en` is low. The bench injects illegal codes and first keeps `en` low, expecting the illegal code and its two-input decode to stay put. It then raises `en` and expects the repaired path to reach a legal code within five clocks and to continue with the correct successor.

// File: rtl/jc_pkg.sv
package jc_pkg;

   localparam int unsigned JC_STAGES_DEF = 4;

   function automatic int unsigned jc_strobe_count(input int unsigned stages);
      return 2 * stages;
   endfunction

   typedef enum logic {
      JC_FB_PLAIN  = 1'b0,
      JC_FB_REPAIR = 1'b1
   } jc_fb_e;

endpackage

// File: rtl/jc_stage_reg.sv
module jc_stage_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      if (WIDTH < 2) $error("jc_stage_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] state_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_r <= '0;
      end else if (en) begin
         state_r <= d;
      end
   end

   assign q = state_r;

endmodule

// File: rtl/jc_feedback.sv
module jc_feedback
   import jc_pkg::*;
#(
   parameter int unsigned STAGES = JC_STAGES_DEF,
   parameter jc_fb_e      FB     = JC_FB_REPAIR
) (
   input  logic [STAGES-1:0] cur,
   output logic [STAGES-1:0] nxt
);

   localparam int unsigned TOP  = STAGES - 1;
   localparam int unsigned FIXP = 2;

   initial begin
      if (STAGES < 2) $error("jc_feedback: STAGES must be at least 2");
      if (FB == JC_FB_REPAIR && STAGES != 4)
         $error("jc_feedback: repair term is defined for four stages only");
   end

   // position-ordered view: pos[0] is the first stage
   logic [STAGES-1:0] pos;
   logic [STAGES-1:0] pos_nxt;

   for (genvar p = 0; p < STAGES; p++) begin : g_view
      assign pos[p] = cur[TOP-p];
      assign nxt[TOP-p] = pos_nxt[p];
   end

   assign pos_nxt[0] = ~pos[TOP];

   for (genvar p = 1; p < STAGES; p++) begin : g_shift
      if (FB == JC_FB_REPAIR && p == FIXP) begin : g_fix
         assign pos_nxt[p] = (pos[0] | pos[p]) & pos[p-1];
      end else begin : g_plain
         assign pos_nxt[p] = pos[p-1];
      end
   end

endmodule

// File: rtl/jc_strobe_dec.sv
module jc_strobe_dec
   import jc_pkg::*;
#(
   parameter int unsigned STAGES = JC_STAGES_DEF,
   localparam int unsigned NSTB  = 2 * STAGES
) (
   input  logic [STAGES-1:0] cur,
   output logic [NSTB-1:0]   stb
);

   localparam int unsigned TOP = STAGES - 1;

   initial begin
      if (NSTB != jc_strobe_count(STAGES)) $error("jc_strobe_dec: strobe count mismatch");
   end

   logic [STAGES-1:0] pos;

   for (genvar p = 0; p < STAGES; p++) begin : g_view
      assign pos[p] = cur[TOP-p];
   end

   for (genvar j = 0; j < NSTB; j++) begin : g_term
      if (j == 0) begin : g_all_low
         assign stb[j] = ~pos[0] & ~pos[TOP];
      end else if (j < STAGES) begin : g_fill_edge
         assign stb[j] = pos[j-1] & ~pos[j];
      end else if (j == STAGES) begin : g_all_high
         assign stb[j] = pos[0] & pos[TOP];
      end else begin : g_drain_edge
         assign stb[j] = ~pos[j-STAGES-1] & pos[j-STAGES];
      end
   end

endmodule

// File: rtl/jc_timing_gen.sv
module jc_timing_gen
   import jc_pkg::*;
#(
   parameter int unsigned STAGES = JC_STAGES_DEF,
   parameter bit          REPAIR = 1'b1,
   localparam int unsigned NSTB  = 2 * STAGES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   output logic [STAGES-1:0] ring_q,
   output logic [NSTB-1:0]   strobe
);

   localparam jc_fb_e FB_SEL = REPAIR ? JC_FB_REPAIR : JC_FB_PLAIN;

   initial begin
      if (STAGES != 4) $error("jc_timing_gen: only four stages are supported");
   end

   logic [STAGES-1:0] nxt_w;
   logic [STAGES-1:0] cur_w;

   jc_feedback #(
      .STAGES (STAGES),
      .FB     (FB_SEL)
   ) u_fb (
      .cur (cur_w),
      .nxt (nxt_w)
   );

   jc_stage_reg #(
      .WIDTH (STAGES)
   ) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .d   (nxt_w),
      .q   (cur_w)
   );

   jc_strobe_dec #(
      .STAGES (STAGES)
   ) u_dec (
      .cur (cur_w),
      .stb (strobe)
   );

   assign ring_q = cur_w;

endmodule

// File: rtl/jc_timing_gen_chk.sv
module jc_timing_gen_chk #(
   parameter int unsigned STAGES = 4,
   parameter bit          REPAIR = 1'b1,
   localparam int unsigned NSTB  = 2 * STAGES
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic [STAGES-1:0] ring_q,
   input logic [NSTB-1:0]   strobe
);

   function automatic logic legal(input logic [STAGES-1:0] v);
      case (v)
         4'h0, 4'h8, 4'hC, 4'hE, 4'hF, 4'h7, 4'h3, 4'h1: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   AST_SHIFT_RULE: assert property (@(posedge clk) disable iff (rst)
      en |=> (ring_q[3] == ~$past(ring_q[0])) && (ring_q[2] == $past(ring_q[3]))
             && (ring_q[0] == $past(ring_q[1]))); // R2

   AST_LEGAL_STAYS: assert property (@(posedge clk) disable iff (rst)
      (en && legal(ring_q)) |=> legal(ring_q)); // R2

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
      legal(ring_q) |-> ($countones(strobe) == 1)); // R3

   AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(ring_q) && $stable(strobe))); // R5

   if (REPAIR) begin : g_rep
      AST_REPAIR_TERM: assert property (@(posedge clk) disable iff (rst)
         en |=> ring_q[1] == (($past(ring_q[3]) | $past(ring_q[1])) & $past(ring_q[2]))); // R6
   end

endmodule

bind jc_timing_gen jc_timing_gen_chk #(.STAGES(STAGES), .REPAIR(REPAIR)) u_chk (.*);

// File: tb/test_jc_timing_gen.sv
module test_jc_timing_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [3:0] ring_q;
   logic [7:0] strobe;

   int unsigned n_run  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   logic [3:0] seq [8] = '{4'h0, 4'h8, 4'hC, 4'hE, 4'hF, 4'h7, 4'h3, 4'h1};
   logic [3:0] bad [8] = '{4'h2, 4'h4, 4'h5, 4'h6, 4'h9, 4'hA, 4'hB, 4'hD};

   always #5 clk = ~clk;

   jc_timing_gen i_jc_timing_gen (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .ring_q (ring_q),
      .strobe (strobe)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic int idx_of(input logic [3:0] v);
      for (int i = 0; i < 8; i++) if (seq[i] == v) return i;
      return -1;
   endfunction

   task automatic do_reset();
      rst = 1'b1; en = 1'b0;
      tick(2);
      rst = 1'b0;
   endtask

   task automatic inject(input logic [3:0] code);
      rst = 1'b1; en = 1'b1;
      force i_jc_timing_gen.u_reg.state_r = code;
      tick(1);
      release i_jc_timing_gen.u_reg.state_r;
      rst = 1'b0; en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check(ring_q == 4'h0, "R1 ring", 8'(ring_q), 8'h00);
      check(strobe == 8'h01, "R1 strobe", strobe, 8'h01);
   endtask

   task automatic t_sequence();
      do_reset();
      en = 1'b1;
      for (int k = 1; k <= 16; k++) begin
         tick(1);
         check(ring_q == seq[k % 8], "R2 cycle", 8'(ring_q), 8'(seq[k % 8]));
         check(strobe == 8'(1 << (k % 8)), "R3 strobe", strobe, 8'(1 << (k % 8)));
      end
      en = 1'b0;
   endtask

   task automatic t_hold();
      do_reset();
      en = 1'b1; tick(3);
      en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick(1);
         check(ring_q == 4'hE, "R5 hold ring", 8'(ring_q), 8'h0E);
         check(strobe == 8'h08, "R5 hold strobe", strobe, 8'h08);
      end
      // gapped enable: advance on every other clock
      for (int k = 0; k < 4; k++) begin
         en = 1'b1; tick(1);
         en = 1'b0; tick(1);
         check(ring_q == seq[(4 + k) % 8], "R5 gapped", 8'(ring_q), 8'(seq[(4 + k) % 8]));
      end
   endtask

   task automatic t_reset_priority();
      do_reset();
      en = 1'b1; tick(5);
      check(ring_q == 4'h7, "R2 mid", 8'(ring_q), 8'h07);
      rst = 1'b1; tick(1);
      check(ring_q == 4'h0, "R7 reset over enable", 8'(ring_q), 8'h00);
      rst = 1'b0; en = 1'b0;
   endtask

   task automatic t_decode_illegal();
      do_reset();
      inject(4'h4);
      check(strobe == 8'h25, "R4 code 4", strobe, 8'h25);
      inject(4'hA);
      check(strobe == 8'h4A, "R4 code A", strobe, 8'h4A);
      inject(4'h9);
      check(strobe == 8'h92, "R4 code 9", strobe, 8'h92);
      tick(2);
      check(ring_q == 4'h9, "R5 illegal held", 8'(ring_q), 8'h09);
      check(strobe == 8'h92, "R5 illegal strobe held", strobe, 8'h92);
   endtask

   task automatic t_repair();
      do_reset();
      inject(4'h6);
      en = 1'b1; tick(1); en = 1'b0;
      check(ring_q == 4'hB, "R6 step from 6", 8'(ring_q), 8'h0B);
      inject(4'hA);
      en = 1'b1; tick(1); en = 1'b0;
      check(ring_q == 4'hD, "R6 step from A", 8'(ring_q), 8'h0D);
      for (int c = 0; c < 8; c++) begin
         int steps;
         int at;
         inject(bad[c]);
         en = 1'b1;
         steps = 0;
         while (idx_of(ring_q) < 0 && steps < 6) begin
            tick(1);
            steps++;
         end
         check(steps <= 5, "R6 recovery bound", 8'(steps), 8'h05);
         at = idx_of(ring_q);
         tick(1);
         if (at >= 0)
            check(ring_q == seq[(at + 1) % 8], "R6 resumes cycle", 8'(ring_q), 8'(seq[(at + 1) % 8]));
         en = 1'b0;
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      t_sequence();
      t_hold();
      t_reset_priority();
      t_decode_illegal();
      t_repair();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule